// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block turns a fast module clock into the serial clock of a SPI master. A control word chooses between two division laws. The linear law divides by an even ratio, 2×(n+1), taken from an 8-bit field. The power-of-two law divides by 2^(n+1), taken from a 4-bit field. The linear law reaches ratios up to 512. Slower rates need the power-of-two law. The fastest setting in either law is divide by two.

The transfer engine raises `run_i` while a transfer is in progress. During that time the block toggles `sclk_o` once every half period. In the cycle where `sclk_o` leaves its idle level it raises a one-cycle `lead_tick_o`, and in the cycle where `sclk_o` returns to idle it raises `trail_tick_o`. The engine uses these two ticks to decide when to sample and when to shift.

When `run_i` is low, the counter is cleared and `sclk_o` sits at the idle level given by `cpol_i`. A changed divider setting takes effect only at the end of a full period or while idle, so a setting change never produces a shortened pulse. Choosing a divider value for a target rate is left to software.

Top module: `sclk_divgen`

## Requirements
- R1: With control bit 12 set (linear law), the 8-bit value n in bits [7:0] gives a half period of n+1 module clocks, so a full serial period is 2×(n+1) clocks.
- R2: With control bit 12 clear (power-of-two law), the 4-bit value n in bits [11:8] gives a half period of 2^n clocks, so a full period is 2^(n+1) clocks.
- R3: After `run_i` is sampled high for H consecutive rising edges (H = half period), `sclk_o` leaves the idle level and `lead_tick_o` is high for that one cycle. H edges later, `sclk_o` returns to the idle level with `trail_tick_o`. This pattern repeats for as long as `run_i` stays high.
- R4: Each tick lasts one cycle. The two ticks are never high together, and they alternate, starting with a leading tick.
- R5: One clock after `run_i` is sampled low, `sclk_o` equals the idle level and both ticks are low. A later restart begins with a full half period.
- R6: A control word changed while running takes effect at the edge that produces the next trailing tick. A control word changed while idle is used by the next run.
- R7: n = 0 in either law gives divide by two: `sclk_o` toggles on every clock while running.
- R8: The largest linear value, n = 255, gives a half period of 256 clocks (a ratio of 512).
- R9: While `rst_ni` is low, `sclk_o`, `lead_tick_o` and `trail_tick_o` are all low.
- R10: The idle level is `cpol_i` as sampled one clock earlier. With `cpol_i` = 1 the running waveform is the inverse of the `cpol_i` = 0 waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_word_i | input | 13 | [7:0] linear value, [11:8] power-of-two value, [12] law select (1 = linear) |
| cpol_i | input | 1 | Idle level of the serial clock |
| run_i | input | 1 | High while the transfer engine wants clock edges |
| sclk_o | output | 1 | Serial clock, with the idle level applied |
| lead_tick_o | output | 1 | One-cycle pulse when `sclk_o` leaves the idle level |
| trail_tick_o | output | 1 | One-cycle pulse when `sclk_o` returns to the idle level |

## Verification
The hardest case to reach is a control word that changes in the middle of a period. The new half length must stay hidden until the trailing edge. The bench reaches this case by switching from a half period of 2 to a half period of 3 one cycle into a run, and then checking that the first trailing edge still comes on the old schedule. A second hard case is a stop in the middle of a half period followed by a restart, which shows whether the counter was really cleared. The deep settings (linear 255, power-of-two 4) are driven for more than a full period, so the count limits themselves are exercised.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
  typedef enum logic {
    LAW_POW2 = 1'b0,
    LAW_LIN  = 1'b1
  } div_law_e;

  typedef struct packed {
    logic lead;
    logic trail;
  } edge_tick_t;
endpackage

// File: rtl/sdg_ratio_decode.sv
module sdg_ratio_decode
  import sdg_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  parameter int CNT_W = 15
) (
  input  logic [LIN_W-1:0] lin_n_i,
  input  logic [POW_W-1:0] pow_n_i,
  input  div_law_e         law_i,
  output logic [CNT_W-1:0] half_m1_o
);
  logic [CNT_W-1:0] lin_m1;
  logic [CNT_W-1:0] pow_m1;

  generate
    if (CNT_W > LIN_W) begin : g_lin_ext
      assign lin_m1 = {{(CNT_W-LIN_W){1'b0}}, lin_n_i};
    end else begin : g_lin_fit
      assign lin_m1 = lin_n_i[CNT_W-1:0];
    end
  endgenerate

  // 2^n - 1; for the top value of n the shift wraps to zero and the subtraction yields all ones
  assign pow_m1 = (CNT_W'(1) << pow_n_i) - CNT_W'(1);

  always_comb begin
    if (law_i == LAW_LIN) half_m1_o = lin_m1;
    else                  half_m1_o = pow_m1;
  end
endmodule

// File: rtl/sdg_half_counter.sv
module sdg_half_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] lim_next_i,
  input  logic             reload_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             lim_en;
  logic             hit;

  assign hit    = (cnt_q == lim_q);
  assign wrap_o = run_i && hit;
  assign lim_en = !run_i || reload_i;

  always_comb begin
    if (!run_i)   cnt_d = '0;
    else if (hit) cnt_d = '0;
    else          cnt_d = cnt_q + CNT_W'(1);
    lim_d = lim_en ? lim_next_i : lim_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end
endmodule

// File: rtl/sdg_edge_gen.sv
module sdg_edge_gen
  import sdg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       cpol_i,
  input  logic       wrap_i,
  output logic       period_end_o,
  output logic       sclk_o,
  output edge_tick_t tick_o
);
  logic       phase_q, phase_d;
  logic       sclk_q, sclk_d;
  edge_tick_t tick_q, tick_d;

  assign period_end_o = wrap_i && phase_q;

  always_comb begin
    if (!run_i)      phase_d = 1'b0;
    else if (wrap_i) phase_d = !phase_q;
    else             phase_d = phase_q;
    sclk_d       = cpol_i ^ phase_d;
    tick_d.lead  = wrap_i && !phase_q;
    tick_d.trail = wrap_i && phase_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      sclk_q  <= 1'b0;
      tick_q  <= '0;
    end else begin
      phase_q <= phase_d;
      sclk_q  <= sclk_d;
      tick_q  <= tick_d;
    end
  end

  assign sclk_o = sclk_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/sclk_divgen.sv
module sclk_divgen
  import sdg_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  localparam int SEL_BIT = LIN_W + POW_W,
  localparam int CTL_W = SEL_BIT + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTL_W-1:0] ctl_word_i,
  input  logic             cpol_i,
  input  logic             run_i,
  output logic             sclk_o,
  output logic             lead_tick_o,
  output logic             trail_tick_o
);
  localparam int POW_SPAN = (1 << POW_W) - 1;
  localparam int CNT_W = (LIN_W > POW_SPAN) ? LIN_W : POW_SPAN;

  logic [CNT_W-1:0] half_m1;
  logic             wrap;
  logic             period_end;
  div_law_e         law;
  edge_tick_t       tick;

  assign law = div_law_e'(ctl_word_i[SEL_BIT]);

  sdg_ratio_decode #(.LIN_W(LIN_W), .POW_W(POW_W), .CNT_W(CNT_W)) u_decode (
    .lin_n_i   (ctl_word_i[LIN_W-1:0]),
    .pow_n_i   (ctl_word_i[SEL_BIT-1:LIN_W]),
    .law_i     (law),
    .half_m1_o (half_m1)
  );

  sdg_half_counter #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .lim_next_i (half_m1),
    .reload_i   (period_end),
    .wrap_o     (wrap)
  );

  sdg_edge_gen u_edge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .cpol_i       (cpol_i),
    .wrap_i       (wrap),
    .period_end_o (period_end),
    .sclk_o       (sclk_o),
    .tick_o       (tick)
  );

  assign lead_tick_o  = tick.lead;
  assign trail_tick_o = tick.trail;
endmodule

// File: rtl/sdg_checker.sv
module sdg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic cpol_i,
  input logic sclk_o,
  input logic lead_tick_o,
  input logic trail_tick_o
);
  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (sclk_o == $past(cpol_i) && !lead_tick_o && !trail_tick_o)); // R5

  AST_TICK_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_tick_o && trail_tick_o)); // R4

  AST_LEAD_LEAVES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_tick_o |-> (sclk_o == !$past(cpol_i))); // R3

  AST_TRAIL_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_tick_o |-> (sclk_o == $past(cpol_i))); // R3

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_tick_o || trail_tick_o) |-> $past(run_i)); // R5

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!sclk_o && !lead_tick_o && !trail_tick_o); // R9
    end
  end
endmodule

bind sclk_divgen sdg_checker chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_i        (run_i),
  .cpol_i       (cpol_i),
  .sclk_o       (sclk_o),
  .lead_tick_o  (lead_tick_o),
  .trail_tick_o (trail_tick_o)
);

// File: tb/sclk_divgen_tb_top.sv
module sclk_divgen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] ctl;
  logic        cpol;
  logic        run;
  logic        sclk, lead, trail;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sclk_divgen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctl_word_i(ctl), .cpol_i(cpol), .run_i(run),
    .sclk_o(sclk), .lead_tick_o(lead), .trail_tick_o(trail)
  );

  function automatic logic [12:0] mk(bit lin, int n);
    if (lin) return {1'b1, 4'd0, 8'(n)};
    return {1'b0, 4'(n), 8'd0};
  endfunction

  function automatic int half_of(bit lin, int n);
    if (lin) return n + 1;
    return 1 << n;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic stop_run(string req);
    run = 1'b0;
    @(negedge clk);
    chk({req, " R5 idle level"}, sclk, cpol);
    chk({req, " R5 no lead"}, lead, 0);
    chk({req, " R5 no trail"}, trail, 0);
    @(negedge clk);
  endtask

  // Runs ncyc edges; the control word switches after edge chg_at (chg_at < 0: never)
  task automatic run_seq(string req, bit l1, int n1, bit l2, int n2, int chg_at, bit pol, int ncyc);
    int lim, cnt;
    bit ph, exp_lead, exp_trail;
    cpol = pol;
    ctl  = mk(l1, n1);
    @(negedge clk);
    lim = half_of(l1, n1);
    cnt = 0;
    ph  = 1'b0;
    run = 1'b1;
    for (int k = 1; k <= ncyc; k++) begin
      exp_lead  = 1'b0;
      exp_trail = 1'b0;
      if (cnt == lim - 1) begin
        cnt = 0;
        ph  = !ph;
        exp_lead  = ph;
        exp_trail = !ph;
        if (exp_trail) lim = (chg_at >= 0 && k > chg_at) ? half_of(l2, n2) : half_of(l1, n1);
      end else begin
        cnt++;
      end
      @(negedge clk);
      chk({req, " sclk"}, sclk, int'(pol ^ ph));
      chk({req, " lead"}, lead, exp_lead);
      chk({req, " trail"}, trail, exp_trail);
      if (k == chg_at) ctl = mk(l2, n2);
    end
    stop_run(req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; run = 1'b0; cpol = 1'b1; ctl = mk(1, 0);
    repeat (3) @(negedge clk);
    chk("R9 sclk in reset", sclk, 0);
    chk("R9 lead in reset", lead, 0);
    chk("R9 trail in reset", trail, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_idle_follow;
    cpol = 1'b1;
    @(negedge clk);
    chk("R10 idle follows cpol=1", sclk, 1);
    cpol = 1'b0;
    @(negedge clk);
    chk("R10 idle follows cpol=0", sclk, 0);
    repeat (5) begin
      @(negedge clk);
      chk("R5 no tick while idle", int'(lead | trail), 0);
    end
  endtask

  task automatic t_restart;
    cpol = 1'b0; ctl = mk(1, 3);
    @(negedge clk);
    run = 1'b1;
    repeat (6) @(negedge clk);
    stop_run("R5 mid-phase stop");
    run_seq("R5 restart full half", 1, 3, 1, 3, -1, 0, 12);
  endtask

  initial begin
    t_reset();
    t_idle_follow();
    run_seq("R7 R1 lin n=0", 1, 0, 1, 0, -1, 0, 8);
    run_seq("R7 R2 pow n=0", 0, 0, 0, 0, -1, 1, 8);
    run_seq("R1 R3 R4 lin n=3", 1, 3, 1, 3, -1, 0, 24);
    run_seq("R10 R1 lin n=3 cpol1", 1, 3, 1, 3, -1, 1, 24);
    run_seq("R2 pow n=3", 0, 3, 0, 3, -1, 0, 40);
    run_seq("R2 pow n=4", 0, 4, 0, 4, -1, 1, 70);
    run_seq("R8 lin n=255", 1, 255, 1, 255, -1, 0, 520);
    run_seq("R6 change mid-run", 1, 1, 1, 2, 1, 0, 16);
    run_seq("R6 change to pow", 1, 2, 0, 1, 4, 1, 20);
    run_seq("R6 idle change used", 0, 2, 0, 2, -1, 0, 12);
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule